// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Bank

This block is a small bank of 32-bit flag and command registers that two processors share. One processor reaches it over a simple register bus. Each access carries an address, a write strobe, a read strobe, a size code (byte, halfword or word) and write data. Read data comes back on a registered output. The other processor's view of the bank, and any interrupt or transfer logic that watches it, sit outside this block.

The register index comes from address bits [7:4], and it sets how a write acts on the stored word:
- At index 0 a write stores the data.
- At index 2 a write ORs the written one-bits into the stored word.
- At index 3 a write clears the stored bits that are one in the data.
- At index 4 only bit 8 can be written.
- At index 6 a write leaves nothing behind, and a read returns zero.

Reads of index 4 come back with fixed marker bits forced high. Sub-word writes apply the same rule to the bytes they cover. A read always returns the whole 32-bit word.

Top module: `mbx_regbank`

## Requirements
- R1: The bank responds only when `(bus_addr & ADDR_MASK) == BASE_ADDR`. The defaults are mask 0xFFFFFF0F and base 0x1000F200, so address bits [3:0] must be zero. Any other address leaves every register unchanged and reads as 0.
- R2: Index 0 stores the written data on the bytes the access covers. A byte covers bits [7:0], a halfword bits [15:0] and a word all bits. Bytes outside the access keep their value.
- R3: Index 2 ORs the covered bits of the write data into its stored word. No bit is ever cleared.
- R4: Index 3 clears every covered stored bit whose write-data bit is 1. No bit is ever set. Its reset value is the parameter `CLEAR_INIT`, default 0.
- R5: At index 4, a halfword or word write copies `bus_wdata[8]` into stored bit 8. All other stored bits stay zero.
- R6: At index 4, a byte write clears stored bit 8 when `bus_wdata[8]` is 0. It never sets the bit.
- R7: A read of index 4 returns the stored word ORed with 0xF0000102 for a word read and with 0x00000102 for a halfword read. A byte read returns it unmodified.
- R8: A write to index 6 changes no register, and a read of index 6 returns 0.
- R9: Writes to indices 1, 5 and 7 to 15 are ignored, and reads of them return 0.
- R10: Size code 2'b11 is reserved. A write with it changes nothing, and a read with it returns 0. The other codes are 2'b00 byte, 2'b01 halfword and 2'b10 word.
- R11: `bus_rdata` takes the read result on the clock edge that samples `bus_rd` and holds it until the next read. A read issued together with a write returns the contents from before the write.
- R12: Reset sets `bus_rdata` and all stored registers to 0, except index 3, which is set to `CLEAR_INIT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| bus_wdata | input | 32 | Write data, lane-aligned |
| bus_rdata | output | 32 | Registered read data |

## Verification
A write reaches its register on the clock edge that samples the strobe. It is therefore seen by any read strobed one cycle later or after, and a read strobed in the same cycle as the write still returns the old contents. Read data appears on the edge that samples `bus_rd`. The bench pushes each expected word into a queue when it drives a read, and the monitor pops and compares at the next falling edge, half a cycle after that edge. The hold behaviour is checked by sampling again several idle cycles later.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DATA_W   = 32;
    localparam int NCELL    = 4;
    localparam int IDX_W    = 4;
    localparam logic [DATA_W-1:0] WORD_MARK = 32'hF000_0102;
    localparam logic [DATA_W-1:0] HALF_MARK = 32'h0000_0102;
    localparam int CTRL_BIT = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [2:0] {
        MD_STORE,
        MD_SET,
        MD_CLEAR,
        MD_BIT8,
        MD_ZERO,
        MD_NONE
    } reg_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } cell_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    // index of each storage cell and its write rule
    function automatic logic [IDX_W-1:0] cell_index(input int slot);
        case (slot)
            0:       return 4'd0;
            1:       return 4'd2;
            2:       return 4'd3;
            default: return 4'd4;
        endcase
    endfunction

    function automatic reg_mode_e cell_mode(input int slot);
        case (slot)
            0:       return MD_STORE;
            1:       return MD_SET;
            2:       return MD_CLEAR;
            default: return MD_BIT8;
        endcase
    endfunction

endpackage

// File: rtl/mbx_lane_decode.sv
module mbx_lane_decode
    import mbx_pkg::*;
(
    input  logic [1:0]        low_addr,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] bit_mask
);
    localparam int NLANE = DATA_W / 8;

    logic [NLANE-1:0] lanes;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: lanes = NLANE'(1) << low_addr;
            SZ_HALF: lanes = low_addr[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: lanes = '1;
            default: lanes = '0;
        endcase
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign bit_mask[8*g +: 8] = {8{lanes[g]}};
    end

endmodule

// File: rtl/mbx_store_cell.sv
module mbx_store_cell
    import mbx_pkg::*;
#(
    parameter reg_mode_e         MODE = MD_STORE,
    parameter logic [DATA_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              byte_acc,
    input  logic [DATA_W-1:0] lane_bits,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] value
);
    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (wr_en) begin
            case (MODE)
                MD_STORE: cell_d.val = (cell_q.val & ~lane_bits) | (wr_data & lane_bits);
                MD_SET:   cell_d.val = cell_q.val | (wr_data & lane_bits);
                MD_CLEAR: cell_d.val = cell_q.val & ~(wr_data & lane_bits);
                MD_BIT8: begin
                    if (byte_acc) begin
                        if (!wr_data[CTRL_BIT]) cell_d.val[CTRL_BIT] = 1'b0;
                    end else if (lane_bits[CTRL_BIT]) begin
                        cell_d.val[CTRL_BIT] = wr_data[CTRL_BIT];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q.val <= INIT;
        else        cell_q     <= cell_d;
    end

    assign value = cell_q.val;

    if (MODE == MD_SET) begin : g_chk_set
        a_r3_set_only_grows: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> ((value & $past(value)) == $past(value)));
    end
    if (MODE == MD_CLEAR) begin : g_chk_clr
        a_r4_clear_only_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> ((value & ~$past(value)) == '0));
    end
    if (MODE == MD_BIT8) begin : g_chk_bit8
        a_r6_byte_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && byte_acc) |=> !(value[CTRL_BIT] && !$past(value[CTRL_BIT])));
        a_r5_only_bit8: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> ((value & ~(DATA_W'(1) << CTRL_BIT)) == '0));
    end

endmodule

// File: rtl/mbx_read_mux.sv
module mbx_read_mux
    import mbx_pkg::*;
(
    input  logic [IDX_W-1:0]             idx,
    input  logic [1:0]                   size,
    input  logic [NCELL-1:0][DATA_W-1:0] cells,
    output logic [DATA_W-1:0]            rd_word
);
    logic [DATA_W-1:0] raw;
    logic              is_mark;

    always_comb begin
        raw     = '0;
        is_mark = 1'b0;
        for (int s = 0; s < NCELL; s++) begin
            if (idx == cell_index(s)) begin
                raw     = cells[s];
                is_mark = (cell_mode(s) == MD_BIT8);
            end
        end
    end

    always_comb begin
        rd_word = raw;
        if (is_mark) begin
            if (acc_size_e'(size) == SZ_WORD)      rd_word = raw | WORD_MARK;
            else if (acc_size_e'(size) == SZ_HALF) rd_word = raw | HALF_MARK;
        end
        if (acc_size_e'(size) == SZ_RSVD) rd_word = '0;
    end

endmodule

// File: rtl/mbx_regbank.sv
module mbx_regbank
    import mbx_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h1000_F200,
    parameter logic [ADDR_W-1:0] ADDR_MASK  = 32'hFFFF_FF0F,
    parameter logic [31:0]       CLEAR_INIT = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int IDX_LSB = 4;

    logic                         hit;
    logic [IDX_W-1:0]             idx;
    logic [DATA_W-1:0]            lane_bits;
    logic [NCELL-1:0][DATA_W-1:0] cells;
    logic [DATA_W-1:0]            rd_word;
    rd_state_t                    st_d, st_q;

    assign hit = ((bus_addr & ADDR_MASK) == BASE_ADDR);
    assign idx = bus_addr[IDX_LSB +: IDX_W];

    mbx_lane_decode u_lanes (
        .low_addr (bus_addr[1:0]),
        .size     (bus_size),
        .bit_mask (lane_bits)
    );

    for (genvar s = 0; s < NCELL; s++) begin : g_cell
        mbx_store_cell #(
            .MODE (cell_mode(s)),
            .INIT ((cell_mode(s) == MD_CLEAR) ? CLEAR_INIT : 32'h0)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_wr && hit && (idx == cell_index(s))),
            .byte_acc  (acc_size_e'(bus_size) == SZ_BYTE),
            .lane_bits (lane_bits),
            .wr_data   (bus_wdata),
            .value     (cells[s])
        );
    end

    mbx_read_mux u_rmux (
        .idx     (idx),
        .size    (bus_size),
        .cells   (cells),
        .rd_word (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (bus_rd) st_d.rdata = hit ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    a_r1_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> $stable(cells));
    a_r10_rsvd_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size == 2'b11) |=> $stable(cells));
    a_r8_zero_reg_reads_0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && idx == 4'd6) |=> (bus_rdata == '0));
    a_r8_zero_reg_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == 4'd6) |=> $stable(cells));
    a_r7_word_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && idx == 4'd4 && bus_size == 2'b10)
            |=> ((bus_rdata & WORD_MARK) == WORD_MARK));

endmodule

// File: tb/mbx_regbank_bench.sv
module mbx_regbank_bench;
    localparam logic [31:0] B      = 32'h1000_F200;
    localparam logic [31:0] CLR0   = 32'hFFFF_00FF;
    localparam logic [1:0]  BYTE_S = 2'b00;
    localparam logic [1:0]  HALF_S = 2'b01;
    localparam logic [1:0]  WORD_S = 2'b10;
    localparam logic [1:0]  RSVD_S = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    mbx_regbank #(.CLEAR_INIT(CLR0)) u_mbx_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: compare each read result half a cycle after it is registered
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(bus_rdata, e, t);
        end
    end

    task automatic access(input bit w, input bit r, input logic [31:0] a,
                          input logic [1:0] sz, input logic [31:0] d,
                          input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = w; bus_rd = r;
        if (r) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
        access(1'b1, 1'b0, a, sz, d, 32'h0, "");
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] exp, input string tag);
        access(1'b0, 1'b1, a, sz, 32'h0, exp, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_rdata, 32'h0, "R12 rdata after reset");
        rd(B + 32'h00, WORD_S, 32'h0, "R12 index0 reset");
        rd(B + 32'h30, WORD_S, CLR0, "R12 index3 reset");
        rd(B + 32'h40, BYTE_S, 32'h0, "R12 index4 reset");

        // R2 plain store on covered lanes
        wr(B + 32'h00, WORD_S, 32'hA5A5_1234);
        rd(B + 32'h00, WORD_S, 32'hA5A5_1234, "R2 word store");
        wr(B + 32'h00, BYTE_S, 32'hFFFF_FFEE);
        rd(B + 32'h00, WORD_S, 32'hA5A5_12EE, "R2 byte store");
        wr(B + 32'h00, HALF_S, 32'hFFFF_BEEF);
        rd(B + 32'h00, BYTE_S, 32'hA5A5_BEEF, "R2 half store");

        // R3 set register
        wr(B + 32'h20, WORD_S, 32'h0000_00F0);
        rd(B + 32'h20, WORD_S, 32'h0000_00F0, "R3 first set");
        wr(B + 32'h20, WORD_S, 32'h0F00_0001);
        rd(B + 32'h20, WORD_S, 32'h0F00_00F1, "R3 accumulate");
        wr(B + 32'h20, HALF_S, 32'hFFFF_0100);
        rd(B + 32'h20, WORD_S, 32'h0F00_01F1, "R3 half set");

        // R4 clear register
        wr(B + 32'h30, WORD_S, 32'h0000_000F);
        rd(B + 32'h30, WORD_S, 32'hFFFF_00F0, "R4 word clear");
        wr(B + 32'h30, HALF_S, 32'hFFFF_00F0);
        rd(B + 32'h30, WORD_S, 32'hFFFF_0000, "R4 half clear");
        wr(B + 32'h30, WORD_S, 32'h0001_0000);
        rd(B + 32'h30, WORD_S, 32'hFFFE_0000, "R4 upper clear");

        // R5 R6 R7 control bit and read marks
        wr(B + 32'h40, WORD_S, 32'hFFFF_FFFF);
        rd(B + 32'h40, BYTE_S, 32'h0000_0100, "R5 word sets bit8 only");
        rd(B + 32'h40, WORD_S, 32'hF000_0102, "R7 word mark");
        rd(B + 32'h40, HALF_S, 32'h0000_0102, "R7 half mark");
        wr(B + 32'h40, BYTE_S, 32'h0000_0100);
        rd(B + 32'h40, BYTE_S, 32'h0000_0100, "R6 byte keeps bit8");
        wr(B + 32'h40, BYTE_S, 32'hFFFF_FEFF);
        rd(B + 32'h40, BYTE_S, 32'h0000_0000, "R6 byte clears bit8");
        wr(B + 32'h40, BYTE_S, 32'h0000_0100);
        rd(B + 32'h40, BYTE_S, 32'h0000_0000, "R6 byte cannot set");
        wr(B + 32'h40, HALF_S, 32'h0000_0100);
        rd(B + 32'h40, BYTE_S, 32'h0000_0100, "R5 half sets bit8");
        wr(B + 32'h40, WORD_S, 32'h0000_0000);
        rd(B + 32'h40, BYTE_S, 32'h0000_0000, "R5 word clears bit8");

        // R8 zero register
        wr(B + 32'h60, WORD_S, 32'hFFFF_FFFF);
        rd(B + 32'h60, WORD_S, 32'h0, "R8 zero reads 0");
        rd(B + 32'h00, WORD_S, 32'hA5A5_BEEF, "R8 others untouched");

        // R9 undefined indices
        wr(B + 32'h10, WORD_S, 32'h1234_5678);
        rd(B + 32'h10, WORD_S, 32'h0, "R9 index1 reads 0");
        wr(B + 32'h50, WORD_S, 32'hFFFF_FFFF);
        rd(B + 32'h50, WORD_S, 32'h0, "R9 index5 reads 0");
        rd(B + 32'h20, WORD_S, 32'h0F00_01F1, "R9 set reg untouched");

        // R1 address decode
        wr(32'h1000_F300, WORD_S, 32'h0);
        wr(B + 32'h01, BYTE_S, 32'h0);
        rd(B + 32'h00, WORD_S, 32'hA5A5_BEEF, "R1 miss writes ignored");
        rd(32'h1000_F300, WORD_S, 32'h0, "R1 miss read 0");
        rd(B + 32'h02, HALF_S, 32'h0, "R1 low nibble miss");

        // R10 reserved size
        wr(B + 32'h00, RSVD_S, 32'h0);
        rd(B + 32'h00, RSVD_S, 32'h0, "R10 reserved read 0");
        rd(B + 32'h00, WORD_S, 32'hA5A5_BEEF, "R10 reserved write ignored");

        // R11 read with write returns old value, then holds
        access(1'b1, 1'b1, B + 32'h00, WORD_S, 32'h1111_2222, 32'hA5A5_BEEF, "R11 read before write");
        rd(B + 32'h00, WORD_S, 32'h1111_2222, "R11 new value");
        repeat (3) @(negedge clk);
        check(bus_rdata, 32'h1111_2222, "R11 holds when idle");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule